// File: doc/BRIEF.md
# Serial Memory Status and Write-Enable Front End

This block sits behind the serial interface of a serial-bus memory slave. It handles the command-level side of the status byte. It decodes three 8-bit instructions from the incoming bit stream: arm writes, read status and write status. It holds the protection bits and the write-enable latch. It also models the internal programming cycle as a busy countdown. The memory array itself is not part of this block. The block only raises a one-cycle `wr_cycle_start` pulse when a status write is accepted.

The serial pins are sampled on the block's own clock, so the serial clock must be several system clocks slow. Data is captured on rising serial-clock edges and driven on falling edges. An active-low protect pin can lock the protection bits while the protect-enable status bit is set. A protect request seen at any point during a status-write frame cancels that frame. Once a programming cycle has begun, the pin has no further effect on it.

Top module: `ssp_status_front`

## Requirements
- R1: After reset the status byte reads 0x00 and `spi_miso_oe` is 0.
- R2: The arm instruction 0x06 sets the write-enable latch (status bit 1) only when chip select rises after exactly 8 serial clocks.
- R3: A write-status frame (0x01 then one data byte) is ignored when the write-enable latch is clear.
- R4: An accepted status write updates only bit 7 (protect enable), bit 3 and bit 2 (block-protect bits) from the data byte. Bits 6:4 always read 0, and bits 1:0 reflect only busy and the latch.
- R5: With protect enable at 1 and `spi_wp_n` low when chip select rises, a status write is refused, and the latch stays set.
- R6: If `spi_wp_n` is low at any cycle of a write-status frame while protect enable is 1, that write is cancelled even if the pin is high again when chip select rises.
- R7: With protect enable at 0, `spi_wp_n` has no effect on status writes.
- R8: A status write launches, with a one-cycle `wr_cycle_start` pulse, only when chip select rises after exactly 16 serial clocks. Frames of 15 or 17 clocks change nothing.
- R9: After a launch, status bit 0 (busy) reads 1 for WRITE_CYCLES clocks. The latch clears when busy ends. While busy, arm and write instructions are ignored, and `spi_wp_n` does not affect the running cycle.
- R10: Read-status (0x05) drives the live status byte MSB first. The first bit is valid after the falling edge that ends the opcode. The byte repeats for as long as the clock runs, including during busy.
- R11: Any other opcode leaves `spi_miso_oe` at 0 and changes no state. The output is disabled whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_wp_n | input | 1 | Active-low write-protect pin |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` |
| wr_cycle_start | output | 1 | One-cycle pulse when a status write launches |

## Verification
The hardest situation to reach is a protect request that is brief and sits entirely inside a write-status frame. The pin is low for a few cycles during the data byte and high again before chip select rises. At the frame edge nothing looks wrong, so a design that checks the pin only at that edge would accept the write. The bench drives the write-status opcode, pulses the pin low partway through the data byte and releases it. It then confirms through a later read-status frame that the protection bits and the latch are unchanged. A companion scenario lowers the pin just after a launch, while busy is set, and shows that the new bits still land.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  localparam logic [7:0] OP_ARM   = 8'h06;
  localparam logic [7:0] OP_WRSTS = 8'h01;
  localparam logic [7:0] OP_RDSTS = 8'h05;

  // Writable protection fields: {enable, bp_hi, bp_lo}
  typedef struct packed {
    logic wpen;
    logic bp1;
    logic bp0;
  } prot_t;

  function automatic logic [7:0] status_byte(prot_t p, logic wel, logic busy);
    return {p.wpen, 3'b000, p.bp1, p.bp0, wel, busy};
  endfunction

  function automatic prot_t prot_from_byte(logic [7:0] d);
    prot_t p;
    p.wpen = d[7];
    p.bp1  = d[3];
    p.bp0  = d[2];
    return p;
  endfunction

  function automatic logic wp_blocks(logic wpen, logic wp_n);
    return wpen & ~wp_n;
  endfunction

endpackage

// File: rtl/ssp_bit_shifter.sv
module ssp_bit_shifter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             mosi,
  output logic             sck_rise,
  output logic             sck_fall,
  output logic             cs_rise,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [7:0]       opcode,
  output logic [7:0]       data
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic       sck_q, cs_q;
  logic [7:0] sh_q, op_q;
  logic [CNT_W-1:0] cnt_q;

  assign sck_rise = sck & ~sck_q & ~cs_n;
  assign sck_fall = ~sck & sck_q & ~cs_n;
  assign cs_rise  = cs_n & ~cs_q;
  assign bit_cnt  = cnt_q;
  assign opcode   = op_q;
  assign data     = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      sh_q  <= '0;
      op_q  <= '0;
      cnt_q <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n) begin
        cnt_q <= '0;
      end else if (sck_rise) begin
        sh_q <= {sh_q[6:0], mosi};
        if (cnt_q == CNT_W'(7)) op_q <= {sh_q[6:0], mosi};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/ssp_status_reg.sv
module ssp_status_reg
  import ssp_pkg::*;
#(
  parameter int WRITE_CYCLES = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_req,
  input  logic       wr_req,
  input  logic [7:0] wr_data,
  output logic [7:0] status,
  output prot_t      prot,
  output logic       busy,
  output logic       wr_start
);

  localparam int CW = $clog2(WRITE_CYCLES + 1);

  prot_t       prot_q;
  logic        wel_q, busy_q, start_q;
  logic [CW-1:0] cnt_q;
  logic        accept;

  assign accept   = wr_req & wel_q & ~busy_q;
  assign status   = status_byte(prot_q, wel_q, busy_q);
  assign prot     = prot_q;
  assign busy     = busy_q;
  assign wr_start = start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q  <= '0;
      wel_q   <= 1'b0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      start_q <= accept;
      if (accept) begin
        prot_q <= prot_from_byte(wr_data);
        busy_q <= 1'b1;
        cnt_q  <= CW'(WRITE_CYCLES);
      end else if (busy_q) begin
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          wel_q  <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (arm_req) begin
        wel_q <= 1'b1;
      end
    end
  end

  AST_LAUNCH_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(wel_q)); // R3
  AST_PROT_ONLY_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_q) |-> $rose(busy_q)); // R4
  AST_PROT_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(prot_q)); // R9
  AST_WEL_CLEARS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> !wel_q); // R9

endmodule

// File: rtl/ssp_status_front.sv
module ssp_status_front
  import ssp_pkg::*;
#(
  parameter int WRITE_CYCLES = 400,
  parameter int CNT_W        = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  input  logic spi_wp_n,
  output logic spi_miso,
  output logic spi_miso_oe,
  output logic wr_cycle_start
);

  localparam logic [CNT_W-1:0] ARM_BITS = CNT_W'(8);
  localparam logic [CNT_W-1:0] WR_BITS  = CNT_W'(16);

  logic             sck_rise, sck_fall, cs_rise;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0]       opcode, rx_data, status;
  prot_t            prot;
  logic             busy;

  // Named decode events
  logic arm_req, wr_req, wp_now, rd_phase;
  logic cancel_q;
  logic [7:0] out_sh_q;
  logic [2:0] out_cnt_q;
  logic       oe_q;

  ssp_bit_shifter #(.CNT_W(CNT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (spi_sck),
    .cs_n     (spi_cs_n),
    .mosi     (spi_mosi),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_rise  (cs_rise),
    .bit_cnt  (bit_cnt),
    .opcode   (opcode),
    .data     (rx_data)
  );

  assign wp_now   = wp_blocks(prot.wpen, spi_wp_n);
  assign arm_req  = cs_rise & (opcode == OP_ARM) & (bit_cnt == ARM_BITS);
  assign wr_req   = cs_rise & (opcode == OP_WRSTS) & (bit_cnt == WR_BITS)
                    & ~cancel_q & ~wp_now;
  assign rd_phase = ~spi_cs_n & (opcode == OP_RDSTS) & (bit_cnt >= ARM_BITS);

  ssp_status_reg #(.WRITE_CYCLES(WRITE_CYCLES)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_req  (arm_req),
    .wr_req   (wr_req),
    .wr_data  (rx_data),
    .status   (status),
    .prot     (prot),
    .busy     (busy),
    .wr_start (wr_cycle_start)
  );

  // Sticky protect request seen during the current frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cancel_q <= 1'b0;
    else if (spi_cs_n) cancel_q <= 1'b0;
    else if (wp_now)   cancel_q <= 1'b1;
  end

  // Status read-out: reload every 8 bits so the live value repeats
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sh_q  <= '0;
      out_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (spi_cs_n) begin
      out_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (sck_fall && rd_phase) begin
      oe_q      <= 1'b1;
      out_cnt_q <= out_cnt_q + 1'b1;
      if (out_cnt_q == 3'd0) out_sh_q <= status;
      else                   out_sh_q <= {out_sh_q[6:0], 1'b0};
    end
  end

  assign spi_miso    = out_sh_q[7];
  assign spi_miso_oe = oe_q;

  AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |=> !spi_miso_oe); // R11
  AST_CANCEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel_q && cs_rise) |=> !wr_cycle_start); // R6
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !wr_cycle_start); // R9

endmodule

// File: tb/ssp_status_front_tb.sv
module ssp_status_front_tb_top;

  localparam int WCYC = 400;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  logic miso, miso_oe, wr_start;

  int checks = 0, fails = 0, starts = 0;
  bit oe_seen = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ssp_status_front #(.WRITE_CYCLES(WCYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_wp_n(wp_n), .spi_miso(miso),
    .spi_miso_oe(miso_oe), .wr_cycle_start(wr_start)
  );

  always @(negedge clk) begin
    if (wr_start) starts++;
    if (miso_oe) oe_seen = 1'b1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    @(negedge clk); cs_n = 1'b0; wait_clk(HALF);
  endtask

  task automatic desel();
    wait_clk(HALF); cs_n = 1'b1; wait_clk(4);
  endtask

  // Shift n bits MSB first from tx[n-1]; rx holds miso sampled before each rise
  task automatic xfer(input logic [23:0] tx, input int n, output logic [23:0] rx);
    rx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      mosi = tx[i];
      wait_clk(HALF);
      rx[i] = miso;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic cmd(input logic [23:0] tx, input int n);
    logic [23:0] rx;
    sel(); xfer(tx, n, rx); desel();
  endtask

  task automatic read_status(output logic [7:0] s);
    logic [23:0] rx;
    sel(); xfer({16'h0, 8'h05, 8'h00}, 16, rx); desel();
    s = rx[7:0];
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R1 oe at reset", miso_oe, 0);
    read_status(s);
    chk("R1 status at reset", s, 8'h00);
  endtask

  task automatic t_write_locked();
    logic [7:0] s;
    cmd({8'h0, 8'h01, 8'h8C}, 16);
    read_status(s);
    chk("R3 status unchanged", s, 8'h00);
    chk("R3 no launch", starts, 0);
    cmd({15'h0, 8'h06, 1'b0}, 9);
    read_status(s);
    chk("R2 nine clocks do not arm", s, 8'h00);
    cmd({16'h0, 8'h06}, 8);
    read_status(s);
    chk("R2 armed", s, 8'h02);
  endtask

  task automatic t_write_and_busy();
    logic [7:0] s;
    cmd({8'h0, 8'h01, 8'hFF}, 16);
    chk("R8 launch pulse", starts, 1);
    wp_n = 1'b0;
    read_status(s);
    chk("R9 R10 busy read", s, 8'h8F);
    cmd({16'h0, 8'h06}, 8);
    cmd({8'h0, 8'h01, 8'h00}, 16);
    chk("R9 no launch while busy", starts, 1);
    wait_clk(WCYC + 20);
    wp_n = 1'b1;
    read_status(s);
    chk("R4 R9 after cycle", s, 8'h8C);
  endtask

  task automatic t_protect();
    logic [7:0] s;
    logic [23:0] rx;
    cmd({16'h0, 8'h06}, 8);
    wp_n = 1'b0;
    cmd({8'h0, 8'h01, 8'h00}, 16);
    wp_n = 1'b1;
    read_status(s);
    chk("R5 refused, latch kept", s, 8'h8E);
    chk("R5 no launch", starts, 1);
    sel();
    xfer({16'h0, 8'h01}, 8, rx);
    xfer({20'h0, 4'h0}, 4, rx);
    wp_n = 1'b0; wait_clk(3); wp_n = 1'b1;
    xfer({20'h0, 4'h0}, 4, rx);
    desel();
    read_status(s);
    chk("R6 brief pulse cancels", s, 8'h8E);
    chk("R6 no launch", starts, 1);
    cmd({8'h0, 8'h01, 8'h04}, 16);
    wait_clk(WCYC + 20);
    read_status(s);
    chk("R4 unlocked write", s, 8'h04);
  endtask

  task automatic t_pin_ignored();
    logic [7:0] s;
    cmd({16'h0, 8'h06}, 8);
    wp_n = 1'b0;
    cmd({8'h0, 8'h01, 8'h08}, 16);
    wp_n = 1'b1;
    chk("R7 launch", starts, 3);
    wait_clk(WCYC + 20);
    read_status(s);
    chk("R7 write landed", s, 8'h08);
  endtask

  task automatic t_bit_count();
    logic [7:0] s;
    cmd({16'h0, 8'h06}, 8);
    cmd({9'h0, 8'h01, 7'h7F}, 15);
    cmd({7'h0, 8'h01, 8'hFF, 1'b1}, 17);
    read_status(s);
    chk("R8 wrong lengths ignored", s, 8'h0A);
    chk("R8 no launch", starts, 3);
  endtask

  task automatic t_bad_opcode();
    logic [7:0] s;
    oe_seen = 1'b0;
    cmd({8'h0, 8'hA5, 8'hFF}, 16);
    chk("R11 oe stayed low", oe_seen, 0);
    read_status(s);
    chk("R11 state kept", s, 8'h0A);
  endtask

  task automatic t_repeat_read();
    logic [23:0] rx;
    sel(); xfer({8'h05, 16'h0}, 24, rx); desel();
    chk("R10 first byte", rx[15:8], 8'h0A);
    chk("R10 repeated byte", rx[7:0], 8'h0A);
    chk("R11 oe off after frame", miso_oe, 0);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_write_locked();
    t_write_and_busy();
    t_protect();
    t_pin_ignored();
    t_bit_count();
    t_bad_opcode();
    t_repeat_read();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule